// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block collects software requests to raise inter-processor interrupts in a small multiprocessor system of one to eight CPUs. A request names an interrupt ID in the range 0 to 15, the CPU that sends it, and a mask of target CPUs. For every connected target in the mask, the block sets one pending entry. An entry is keyed by the target, the ID and the source, so the same ID from two senders is held as two separate entries. All pending state is banked per target CPU.

Each CPU has its own acknowledge lane. When the lane raises its acknowledge strobe, the block returns, in the same cycle, one pending entry of that CPU as an ID and a source number. It clears that entry at the next clock edge. Entries are handed out lowest ID first. Among equal IDs, the lowest-numbered source comes first. The interrupts are edge-type, so a repeated request for an entry that is already pending does not stack. Requests that come from a CPU without an interface are dropped, and so are mask bits for such CPUs.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset no entry is pending: every bit of `pend_ids` is 0, and an acknowledge returns `ack_valid` 0.
- R2: A cycle with `req_valid` high and a connected source sets entry (target, `req_id`, `req_src`) in every connected target whose bit in `req_targets` is 1. Bit `c*16+id` of `pend_ids` is high when target c holds ID `id` from any source, starting the cycle after the request edge.
- R3: The same ID sent to one target from two sources is kept as two entries and takes two acknowledges to drain.
- R4: With `ack_req[c]` high, lane c shows `ack_valid[c]`=1, the ID at `ack_id[c*4+:4]` and the source at `ack_src[c*3+:3]` in the same cycle. Selection is lowest ID first, then lowest source. Only that entry is cleared at the clock edge.
- R5: An acknowledge on a CPU with nothing pending gives `ack_valid` 0, `ack_id` 0 and `ack_src` 0, and changes no state.
- R6: Bits of `req_targets` at positions NUM_CPUS and above are ignored.
- R7: A request whose `req_src` is NUM_CPUS or more sets no entry anywhere.
- R8: Requesting an entry that is already pending leaves a single entry, which one acknowledge removes.
- R9: If the acknowledged entry is requested again in the same cycle, it stays pending after the edge.
- R10: An acknowledge on one CPU never clears another CPU's entries.
- R11: With NUM_CPUS=1 the reported source is always 0, and only requests from source 0 are accepted.
- R12: While `req_valid` is low, the request fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_id | input | 4 | Interrupt ID of the request |
| req_src | input | 3 | Number of the sending CPU |
| req_targets | input | 8 | Target CPU mask, bit n for CPU n |
| ack_req | input | NUM_CPUS | Per-CPU acknowledge strobe |
| ack_valid | output | NUM_CPUS | Per-CPU: an entry is returned this cycle |
| ack_id | output | NUM_CPUS*4 | Per-CPU returned ID, lane c at [c*4+:4] |
| ack_src | output | NUM_CPUS*3 | Per-CPU returned source, lane c at [c*3+:3] |
| pend_ids | output | NUM_CPUS*16 | Per-CPU pending-ID vector, bit c*16+id |

## Verification
The assertions assume that reset is held low across at least one rising edge before any request or acknowledge. They also assume that `ack_req` and the request fields are stable around each edge, so the entry returned combinationally is the one cleared. The bench changes every input just after the falling edge and releases reset before the first stimulus, which keeps within both assumptions. Out-of-range sources and mask bits are driven on purpose, because the block defines how it treats them.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int MAX_CPUS = 8;
   localparam int ID_W     = 4;
   localparam int NUM_IDS  = 1 << ID_W;
   localparam int SRC_W    = 3;

   function automatic int entry_count(input int cpus);
      return NUM_IDS * cpus;
   endfunction
endpackage

// File: rtl/sgi_pick.sv
module sgi_pick #(
   parameter int WIDTH = 16,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] vec,
   output logic [WIDTH-1:0] grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      grant = vec & (~vec + WIDTH'(1));
      any   = |vec;
      idx   = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~vec) == '0));  // R4
endmodule

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
   import sgi_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   localparam int W = NUM_IDS * NUM_CPUS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ID_W-1:0]            req_id,
   input  logic [SRC_W-1:0]           req_src,
   input  logic [MAX_CPUS-1:0]        req_targets,
   output logic [NUM_CPUS-1:0][W-1:0] set_vec
);
   logic         src_ok;
   logic [W-1:0] entry_hot;
   logic         unused_mask_hi;

   assign src_ok = req_valid && (int'(req_src) < NUM_CPUS);

   always_comb begin
      entry_hot = '0;
      entry_hot[int'(req_id) * NUM_CPUS + (int'(req_src) % NUM_CPUS)] = 1'b1;
   end

   for (genvar t = 0; t < NUM_CPUS; t++) begin : g_tgt
      assign set_vec[t] = (src_ok && req_targets[t]) ? entry_hot : '0;
   end

   if (NUM_CPUS < MAX_CPUS) begin : g_hi
      assign unused_mask_hi = ^req_targets[MAX_CPUS-1:NUM_CPUS];
   end else begin : g_full
      assign unused_mask_hi = 1'b0;
   end

   AST_DROP_FOREIGN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(req_src) >= NUM_CPUS) |-> (set_vec == '0));  // R7
   AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (set_vec == '0));  // R12
endmodule

// File: rtl/sgi_bank.sv
module sgi_bank
   import sgi_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   localparam int W     = NUM_IDS * NUM_CPUS,
   localparam int IDX_W = $clog2(W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [W-1:0]       set_vec,
   input  logic               ack_req,
   output logic               ack_valid,
   output logic [ID_W-1:0]    ack_id,
   output logic [SRC_W-1:0]   ack_src,
   output logic [NUM_IDS-1:0] pend_ids
);
   logic [W-1:0]     pend_q;
   logic [W-1:0]     grant;
   logic [W-1:0]     clr_vec;
   logic [IDX_W-1:0] sel_idx;
   logic             sel_any;
   logic             ack_fire;

   sgi_pick #(.WIDTH(W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .vec   (pend_q),
      .grant (grant),
      .idx   (sel_idx),
      .any   (sel_any)
   );

   assign ack_fire = ack_req && sel_any;
   assign clr_vec  = ack_fire ? grant : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   assign ack_valid = ack_fire;

   if (NUM_CPUS == 1) begin : g_solo
      assign ack_id  = ack_fire ? ID_W'(sel_idx) : '0;
      assign ack_src = '0;
   end else begin : g_multi
      assign ack_id  = ack_fire ? ID_W'(int'(sel_idx) / NUM_CPUS) : '0;
      assign ack_src = ack_fire ? SRC_W'(int'(sel_idx) % NUM_CPUS) : '0;
   end

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      assign pend_ids[i] = |pend_q[i*NUM_CPUS +: NUM_CPUS];
   end

   AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));  // R2
   AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));  // R8
   AST_ACK_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !set_vec[sel_idx]) |=> !pend_q[$past(sel_idx)]);  // R4
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && set_vec[sel_idx]) |=> pend_q[$past(sel_idx)]);  // R9
   AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && (pend_q == '0)) |-> (!ack_valid && ack_id == '0 && ack_src == '0));  // R5
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int NUM_CPUS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ID_W-1:0]             req_id,
   input  logic [SRC_W-1:0]            req_src,
   input  logic [MAX_CPUS-1:0]         req_targets,
   input  logic [NUM_CPUS-1:0]         ack_req,
   output logic [NUM_CPUS-1:0]         ack_valid,
   output logic [NUM_CPUS*ID_W-1:0]    ack_id,
   output logic [NUM_CPUS*SRC_W-1:0]   ack_src,
   output logic [NUM_CPUS*NUM_IDS-1:0] pend_ids
);
   localparam int W = entry_count(NUM_CPUS);

   if (NUM_CPUS < 1 || NUM_CPUS > MAX_CPUS) begin : g_bad_cpus
      $error("sgi_dispatch: NUM_CPUS out of range");
   end

   logic [NUM_CPUS-1:0][W-1:0] set_vec;

   sgi_req_decode #(.NUM_CPUS(NUM_CPUS)) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_id      (req_id),
      .req_src     (req_src),
      .req_targets (req_targets),
      .set_vec     (set_vec)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
      sgi_bank #(.NUM_CPUS(NUM_CPUS)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_vec   (set_vec[c]),
         .ack_req   (ack_req[c]),
         .ack_valid (ack_valid[c]),
         .ack_id    (ack_id[c*ID_W +: ID_W]),
         .ack_src   (ack_src[c*SRC_W +: SRC_W]),
         .pend_ids  (pend_ids[c*NUM_IDS +: NUM_IDS])
      );

      AST_SRC_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
         ack_valid[c] |-> (int'(ack_src[c*SRC_W +: SRC_W]) < NUM_CPUS));  // R11
      AST_ACK_SHOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
         ack_valid[c] |-> pend_ids[c*NUM_IDS + int'(ack_id[c*ID_W +: ID_W])]);  // R4
   end
endmodule

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_id = '0;
   logic [2:0]    req_src = '0;
   logic [7:0]    req_targets = '0;
   logic [NC-1:0] ack_req = '0;
   logic [NC-1:0] ack_valid;
   logic [NC*4-1:0]  ack_id;
   logic [NC*3-1:0]  ack_src;
   logic [NC*16-1:0] pend_ids;

   logic       s_req_valid = 1'b0;
   logic [3:0] s_req_id = '0;
   logic [2:0] s_req_src = '0;
   logic [7:0] s_req_targets = '0;
   logic       s_ack_req = 1'b0;
   logic       s_ack_valid;
   logic [3:0] s_ack_id;
   logic [2:0] s_ack_src;
   logic [15:0] s_pend_ids;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sgi_dispatch #(.NUM_CPUS(NC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_src(req_src), .req_targets(req_targets), .ack_req(ack_req),
      .ack_valid(ack_valid), .ack_id(ack_id), .ack_src(ack_src), .pend_ids(pend_ids)
   );

   sgi_dispatch #(.NUM_CPUS(1)) uut_solo (
      .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_id(s_req_id),
      .req_src(s_req_src), .req_targets(s_req_targets), .ack_req(s_ack_req),
      .ack_valid(s_ack_valid), .ack_id(s_ack_id), .ack_src(s_ack_src), .pend_ids(s_pend_ids)
   );

   // row: {valid, id, src, mask, expected pend_ids}
   localparam int ROWS = 7;
   localparam logic [79:0] TBL [ROWS] = '{
      {1'b1, 4'd3,  3'd0, 8'h01, 64'h0000_0000_0008_0008 & 64'h0000_0000_0000_0008},
      {1'b1, 4'd3,  3'd1, 8'h03, 64'h0000_0000_0008_0008},
      {1'b1, 4'd15, 3'd2, 8'h0C, 64'h8000_8000_0008_0008},
      {1'b1, 4'd0,  3'd3, 8'hF0, 64'h8000_8000_0008_0008},
      {1'b1, 4'd1,  3'd5, 8'h0F, 64'h8000_8000_0008_0008},
      {1'b1, 4'd1,  3'd3, 8'h04, 64'h8000_8002_0008_0008},
      {1'b0, 4'd9,  3'd0, 8'h0F, 64'h8000_8002_0008_0008}
   };

   function automatic string row_tag(input int r);
      case (r)
         3:       return "R6";
         4:       return "R7";
         6:       return "R12";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [3:0] id, input logic [2:0] src, input logic [7:0] m);
      req_valid = 1'b1; req_id = id; req_src = src; req_targets = m;
      tick();
      req_valid = 1'b0;
   endtask

   task automatic ack(input int cpu, input logic v, input logic [3:0] id,
                      input logic [2:0] src, input string tag);
      ack_req[cpu] = 1'b1;
      #1;
      chk({tag, " valid"}, 64'(ack_valid[cpu]), 64'(v));
      chk({tag, " id"}, 64'(ack_id[cpu*4 +: 4]), 64'(id));
      chk({tag, " src"}, 64'(ack_src[cpu*3 +: 3]), 64'(src));
      tick();
      ack_req[cpu] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 pend", pend_ids, 64'h0);
      ack_req = '1;
      #1;
      chk("R1 ack", 64'(ack_valid), 64'h0);
      ack_req = '0;
      tick();

      for (int r = 0; r < ROWS; r++) begin
         req_valid   = TBL[r][79];
         req_id      = TBL[r][78:75];
         req_src     = TBL[r][74:72];
         req_targets = TBL[r][71:64];
         tick();
         req_valid = 1'b0;
         chk(row_tag(r), pend_ids, TBL[r][63:0]);
      end

      // R3 / R4: two sources of ID 3 at CPU 0, lowest source first
      ack(0, 1'b1, 4'd3, 3'd0, "R3 first");
      chk("R3 one left", 64'(pend_ids[15:0]), 64'h0008);
      ack(0, 1'b1, 4'd3, 3'd1, "R3 second");
      chk("R3 drained", 64'(pend_ids[15:0]), 64'h0);
      chk("R10 cpu1 kept", 64'(pend_ids[31:16]), 64'h0008);
      ack(0, 1'b0, 4'd0, 3'd0, "R5 empty");
      chk("R5 no change", pend_ids, 64'h8000_8002_0008_0000);

      // R4: lowest ID first at CPU 2
      ack(2, 1'b1, 4'd1, 3'd3, "R4 low id");
      ack(2, 1'b1, 4'd15, 3'd2, "R4 next id");
      chk("R10 cpu3 kept", 64'(pend_ids[63:48]), 64'h8000);

      // R8: duplicate request does not stack
      send(4'd2, 3'd0, 8'h02);
      send(4'd2, 3'd0, 8'h02);
      ack(1, 1'b1, 4'd2, 3'd0, "R8 first");
      ack(1, 1'b1, 4'd3, 3'd1, "R8 other");
      ack(1, 1'b0, 4'd0, 3'd0, "R8 none left");

      // R9: re-request in the acknowledge cycle keeps the entry
      send(4'd5, 3'd0, 8'h08);
      req_valid = 1'b1; req_id = 4'd5; req_src = 3'd0; req_targets = 8'h08;
      ack(3, 1'b1, 4'd5, 3'd0, "R9 ack");
      req_valid = 1'b0;
      chk("R9 still pending", 64'(pend_ids[63:48]), 64'h8020);
      ack(3, 1'b1, 4'd5, 3'd0, "R9 again");
      ack(3, 1'b1, 4'd15, 3'd2, "R9 tail");
      chk("R9 drained", pend_ids, 64'h0);

      // R11: single-CPU build
      s_req_valid = 1'b1; s_req_id = 4'd7; s_req_src = 3'd0; s_req_targets = 8'h01;
      tick();
      s_req_valid = 1'b0;
      chk("R11 pend", 64'(s_pend_ids), 64'h0080);
      s_ack_req = 1'b1;
      #1;
      chk("R11 valid", 64'(s_ack_valid), 64'h1);
      chk("R11 id", 64'(s_ack_id), 64'h7);
      chk("R11 src", 64'(s_ack_src), 64'h0);
      tick();
      s_ack_req = 1'b0;
      s_req_valid = 1'b1; s_req_id = 4'd4; s_req_src = 3'd2; s_req_targets = 8'hFF;
      tick();
      s_req_valid = 1'b0;
      chk("R11 foreign src dropped", 64'(s_pend_ids), 64'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule